// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer

This block is the host-side sequencer that programs one word, or the whole array, of a three-wire serial EEPROM organised as 16-bit words. A user request carries a mode bit (single word or fill-all), a word address and a data word. The block turns that request into two serial frames on the chip-select, serial-clock and data-out pins. The first frame is an erase/write-enable command. The second frame is the program command itself. Between the two frames, and again after the second one, it holds chip select low for a minimum gap. It then raises chip select and watches the device's status line until the device reports ready, or until a poll limit runs out. At the end it drops chip select, keeps it low for another minimum gap, and pulses `done`. When the poll limit ran out, it pulses `timeout` in the same cycle as `done`.

The serial clock is the system clock divided by `CLK_DIV` per half period. The serial clock idles low. Data changes together with each falling edge, so it is steady before the device samples it on the rising edge. The minimum chip-select low gap is `TCSL_NS` rounded up to whole system-clock periods: 13 cycles at the 20 ns default. No serial clock runs while the block waits for the device.

The controller is a single state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_EN_SHIFT`: sending the enable frame.
- `ST_EN_GAP`: chip select low after the enable frame.
- `ST_WR_SHIFT`: sending the program frame.
- `ST_WR_GAP`: chip select low before status polling.
- `ST_POLL`: chip select high while reading status.
- `ST_FINISH`: chip select low for a closing gap, with `done` in its last cycle.

The transitions are:
- Accept: `ST_IDLE` to `ST_EN_SHIFT`.
- Last enable bit: `ST_EN_SHIFT` to `ST_EN_GAP`.
- Gap over: `ST_EN_GAP` to `ST_WR_SHIFT`.
- Last program bit: `ST_WR_SHIFT` to `ST_WR_GAP`.
- Gap over: `ST_WR_GAP` to `ST_POLL`.
- Ready seen or limit reached: `ST_POLL` to `ST_FINISH`.
- Closing gap over: `ST_FINISH` to `ST_IDLE`.

Top module: `mw_write_ctrl`

## Requirements
- R1: With `req_wral`=0 the program frame is 25 bits, sent first bit first: `1`, `0`, `1`, then the address (bit 5 first), then the data (bit 15 first).
- R2: With `req_wral`=1 the program frame is 25 bits: `1`, `0`, `0`, `0`, `1`, then four `0` fill bits, then the data (bit 15 first).
- R3: Each request first sends a 9-bit enable frame `1 0 0 1 1 0 0 0 0`, then ends it by lowering chip select.
- R4: Every time chip select rises, it has been low for at least `CSL_CYC` (13) sampled system cycles since it last fell. `done` is only ever high while chip select is low.
- R5: After the program frame and its gap, chip select is raised with the serial clock held low. The block finishes only after the status input reads 1, and the serial clock makes no rising edge during polling. Over a whole request, the rising edges total exactly 34: 9 for the enable frame and 25 for the program frame.
- R6: `done` is high for exactly one cycle per request. `timeout` is 0 when the device reported ready.
- R7: If the status input stays 0 for `POLL_LIMIT` cycles of polling, the block finishes with `done` and `timeout` both high in the same cycle. This happens no sooner than `POLL_LIMIT` cycles after acceptance.
- R8: Each high phase of the serial clock lasts `CLK_DIV` (4) system cycles, and data-out does not change while the serial clock is high.
- R9: `req_ready` is 1 only in `ST_IDLE`. A request is taken when `req_valid` and `req_ready` are both 1. Changes on the request inputs after acceptance have no effect on the frames sent.
- R10: After reset, `cs`, `sclk`, `di`, `done` and `timeout` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_wral | input | 1 | 1 = fill the whole array, 0 = program one word |
| req_addr | input | ADDR_W (6) | Word address for single-word mode |
| req_data | input | DATA_W (16) | Data word to program |
| done | output | 1 | One-cycle pulse at the end of a request |
| timeout | output | 1 | Pulses with `done` when the poll limit expired |
| cs | output | 1 | Device chip select, active high |
| sclk | output | 1 | Device serial clock |
| di | output | 1 | Serial data to the device |
| dout | input | 1 | Serial data and ready/busy status from the device |

## Verification
The checker assumes that `rst_n` is asserted at power-up. It also assumes that `dout` is driven to a definite level, even though the device leaves it floating while chip select is low. It takes a reset as the start of an arbitrarily long low gap on chip select, so the first request may raise chip select at once. The bench device model drives `dout` low whenever chip select is low or the model is busy. It holds every request stable until acceptance and scrambles the inputs only afterwards. A separate mode pins `dout` at 0 to reach the poll limit.

// File: rtl/mw_write_pkg.sv
package mw_write_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EN_SHIFT,
        ST_EN_GAP,
        ST_WR_SHIFT,
        ST_WR_GAP,
        ST_POLL,
        ST_FINISH
    } wr_state_t;

    // Leading bits of each frame: start bit followed by the 2-bit opcode.
    localparam logic [2:0] HDR_PROGRAM = 3'b101;
    localparam logic [2:0] HDR_MISC    = 3'b100;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mw_frame_gen.sv
module mw_frame_gen
    import mw_write_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 3 + ADDR_W + DATA_W,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic               sel_enable,
    input  logic               sel_fill,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   len
);
    localparam logic [ADDR_W-1:0] ENABLE_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] FILL_ADDR   = {2'b01, {(ADDR_W-2){1'b0}}};

    always_comb begin
        if (sel_enable) begin
            frame = {HDR_MISC, ENABLE_ADDR, {DATA_W{1'b0}}};
            len   = LEN_W'(3 + ADDR_W);
        end else if (sel_fill) begin
            frame = {HDR_MISC, FILL_ADDR, data};
            len   = LEN_W'(FRAME_W);
        end else begin
            frame = {HDR_PROGRAM, addr, data};
            len   = LEN_W'(FRAME_W);
        end
    end
endmodule

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d};
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/mw_write_ctrl.sv
module mw_write_ctrl
    import mw_write_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 4,
    parameter int SYS_CLK_NS  = 20,
    parameter int TCSL_NS     = 250,
    parameter int POLL_LIMIT  = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wral,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              timeout,
    output logic              cs,
    output logic              sclk,
    output logic              di,
    input  logic              dout
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int CSL_CYC = ceil_div(TCSL_NS, SYS_CLK_NS);
    localparam int CNT_MAX = (POLL_LIMIT > CSL_CYC) ? POLL_LIMIT : CSL_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    wr_state_t state_q, state_d;

    logic              fill_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [LEN_W-1:0]  left_q;
    logic              sclk_q;
    logic              to_q;
    logic [CW-1:0]     cnt_q;

    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]  frame_len;
    logic              shifting;
    logic              tick;
    logic              fall_evt;
    logic              last_fall;
    logic              gap_over;
    logic              poll_over;
    logic              dout_s;
    logic              ready_seen;
    logic              cnt_clr;

    // ---------------- sub-blocks ----------------
    mw_frame_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .LEN_W  (LEN_W)
    ) u_frame (
        .sel_enable(state_q == ST_IDLE),
        .sel_fill  (fill_q),
        .addr      (addr_q),
        .data      (data_q),
        .frame     (frame),
        .len       (frame_len)
    );

    mw_half_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (shifting),
        .tick (tick)
    );

    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (dout),
        .q    (dout_s)
    );

    // ---------------- decode ----------------
    assign shifting   = (state_q == ST_EN_SHIFT) || (state_q == ST_WR_SHIFT);
    assign fall_evt   = shifting && tick && sclk_q;
    assign last_fall  = fall_evt && (left_q == LEN_W'(1));
    assign gap_over   = (cnt_q == CW'(CSL_CYC - 1));
    assign poll_over  = (cnt_q == CW'(POLL_LIMIT - 1));
    assign ready_seen = dout_s && (cnt_q >= CW'(SYNC_STAGES));

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)               state_d = ST_EN_SHIFT;
            ST_EN_SHIFT: if (last_fall)               state_d = ST_EN_GAP;
            ST_EN_GAP:   if (gap_over)                state_d = ST_WR_SHIFT;
            ST_WR_SHIFT: if (last_fall)               state_d = ST_WR_GAP;
            ST_WR_GAP:   if (gap_over)                state_d = ST_POLL;
            ST_POLL:     if (ready_seen || poll_over) state_d = ST_FINISH;
            ST_FINISH:   if (gap_over)                state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- wait counter ----------------
    assign cnt_clr = (state_d != state_q) || shifting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            shreg_q <= '0;
            left_q  <= '0;
            sclk_q  <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    if (req_valid) begin
                        fill_q  <= req_wral;
                        addr_q  <= req_addr;
                        data_q  <= req_data;
                        shreg_q <= frame;
                        left_q  <= frame_len;
                        to_q    <= 1'b0;
                    end
                end
                ST_EN_SHIFT, ST_WR_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q  <= 1'b0;
                            shreg_q <= shreg_q << 1;
                            left_q  <= left_q - 1'b1;
                        end
                    end
                end
                ST_EN_GAP: begin
                    sclk_q <= 1'b0;
                    if (gap_over) begin
                        shreg_q <= frame;
                        left_q  <= frame_len;
                    end
                end
                ST_POLL: begin
                    sclk_q <= 1'b0;
                    if (poll_over && !ready_seen) begin
                        to_q <= 1'b1;
                    end
                end
                default: begin
                    sclk_q <= 1'b0;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = 1'b0;
        cs        = 1'b0;
        di        = 1'b0;
        done      = 1'b0;
        timeout   = 1'b0;
        sclk      = sclk_q;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_EN_SHIFT: begin cs = 1'b1; di = shreg_q[FRAME_W-1]; end
            ST_WR_SHIFT: begin cs = 1'b1; di = shreg_q[FRAME_W-1]; end
            ST_POLL:     cs = 1'b1;
            ST_FINISH: begin
                done    = gap_over;
                timeout = gap_over && to_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mw_write_ctrl_chk.sv
module mw_write_ctrl_chk #(
    parameter int CSL_CYC = 13
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic timeout,
    input logic cs,
    input logic sclk,
    input logic di
);
    localparam int LW = $clog2(CSL_CYC + 1);

    logic [LW-1:0] low_q;

    // Reset counts as an arbitrarily long low period on chip select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= LW'(CSL_CYC);
        end else if (cs) begin
            low_q <= '0;
        end else if (low_q != LW'(CSL_CYC)) begin
            low_q <= low_q + 1'b1;
        end
    end

    AST_CS_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !$past(cs)) |-> (low_q >= LW'(CSL_CYC))); // R4

    AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cs); // R4

    AST_SCLK_LOW_OUTSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sclk); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done); // R7

    AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sclk && $past(sclk)) |-> $stable(di)); // R8

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cs); // R9
endmodule

bind mw_write_ctrl mw_write_ctrl_chk #(.CSL_CYC(CSL_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .done     (done),
    .timeout  (timeout),
    .cs       (cs),
    .sclk     (sclk),
    .di       (di)
);

// File: tb/mw_write_ctrl_test.sv
module mw_write_ctrl_test;
    localparam int CLK_DIV    = 4;
    localparam int CSL        = 13;
    localparam int POLL_LIMIT = 4000;
    localparam int BUSY       = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_wral = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        done, timeout, cs, sclk, di;
    logic        dout;
    logic        stuck = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mw_write_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wral(req_wral), .req_addr(req_addr), .req_data(req_data),
        .done(done), .timeout(timeout), .cs(cs), .sclk(sclk), .di(di), .dout(dout)
    );

    // ---------------- device model ----------------
    logic [24:0] flog [0:15];
    int          flen [0:15];
    int          nlog = 0;
    logic [24:0] shreg = '0;
    int          nbits = 0;
    int          busy = 0;
    int          cyc = 0;
    int          ready_cyc = 0;
    int          rises = 0;
    int          bad_hi = 0;
    int          bad_low = 0;
    int          hi_len = 0;
    int          low_len = 1000;
    logic        sclk_p = 1'b0;
    logic        cs_p = 1'b0;

    assign dout = cs && (busy == 0) && !stuck;

    always @(posedge clk) begin
        cyc    <= cyc + 1;
        sclk_p <= sclk;
        cs_p   <= cs;
        if (cs && sclk && !sclk_p) begin
            shreg <= {shreg[23:0], di};
            nbits <= nbits + 1;
            rises <= rises + 1;
        end
        if (sclk) begin
            hi_len <= hi_len + 1;
        end else if (sclk_p) begin
            if (hi_len != CLK_DIV) bad_hi <= bad_hi + 1;
            hi_len <= 0;
        end
        if (!cs) begin
            if (low_len < 1000) low_len <= low_len + 1;
        end else begin
            if (!cs_p && low_len < CSL) bad_low <= bad_low + 1;
            low_len <= 0;
        end
        if (!cs && cs_p && nbits != 0) begin
            flog[nlog] <= shreg;
            flen[nlog] <= nbits;
            nlog  <= nlog + 1;
            nbits <= 0;
            shreg <= '0;
            if (nbits == 25) begin
                busy      <= BUSY;
                ready_cyc <= cyc + BUSY;
            end
        end else if (busy != 0) begin
            busy <= busy - 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int  base, rise0, badhi0, badlow0, start_cyc, done_cyc;
    bit  got_done, got_to, ready_leak;

    task automatic run_req(input bit wral, input logic [5:0] a, input logic [15:0] d);
        base = nlog; rise0 = rises; badhi0 = bad_hi; badlow0 = bad_low;
        got_done = 0; got_to = 0; ready_leak = 0;
        @(negedge clk);
        req_valid = 1'b1; req_wral = wral; req_addr = a; req_data = d;
        @(negedge clk);
        start_cyc = cyc;
        req_valid = 1'b0; req_wral = ~wral; req_addr = ~a; req_data = ~d;
        for (int i = 0; i < 20000; i++) begin
            if (done) begin got_done = 1; got_to = timeout; done_cyc = cyc; break; end
            if (req_ready) ready_leak = 1;
            @(negedge clk);
        end
        check(got_done, "R6", "done seen", got_done, 1);
        check(!ready_leak, "R9", "req_ready low while busy", ready_leak, 0);
        @(negedge clk);
        check(!done, "R6", "done one cycle", done, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic common_frames(input logic [24:0] exp_prog);
        check(nlog - base == 2, "R3", "frame count", nlog - base, 2);
        check(flen[base] == 9, "R3", "enable length", flen[base], 9);
        check(flog[base][8:0] == 9'b100110000, "R3", "enable bits", flog[base][8:0], 9'b100110000);
        check(flen[base+1] == 25, "R1", "program length", flen[base+1], 25);
        check(flog[base+1] == exp_prog, "R9", "frame unaffected by late input change", flog[base+1], exp_prog);
        check(rises - rise0 == 34, "R5", "rising edges per request", rises - rise0, 34);
        check(bad_hi == badhi0, "R8", "sclk high phase length", bad_hi - badhi0, 0);
        check(bad_low == badlow0, "R4", "cs low gap", bad_low - badlow0, 0);
    endtask

    task automatic test_reset();
        check(cs == 0 && sclk == 0 && di == 0, "R10", "pins idle", {cs, sclk, di}, 0);
        check(done == 0 && timeout == 0, "R10", "status idle", {done, timeout}, 0);
        check(req_ready == 1, "R10", "ready after reset", req_ready, 1);
    endtask

    task automatic test_write(input logic [5:0] a, input logic [15:0] d);
        run_req(1'b0, a, d);
        common_frames({3'b101, a, d});
        check(flog[base+1] == {3'b101, a, d}, "R1", "write frame", flog[base+1], {3'b101, a, d});
        check(!got_to, "R6", "no timeout", got_to, 0);
        check(done_cyc >= ready_cyc, "R5", "finish after device ready", done_cyc, ready_cyc);
    endtask

    task automatic test_wral(input logic [15:0] d);
        run_req(1'b1, 6'h15, d);
        common_frames({3'b100, 6'b010000, d});
        check(flog[base+1] == {3'b100, 6'b010000, d}, "R2", "fill-all frame",
              flog[base+1], {3'b100, 6'b010000, d});
        check(!got_to, "R6", "no timeout", got_to, 0);
        check(done_cyc >= ready_cyc, "R5", "finish after device ready", done_cyc, ready_cyc);
    endtask

    task automatic test_timeout();
        stuck = 1'b1;
        run_req(1'b0, 6'h3F, 16'hFFFF);
        check(got_to, "R7", "timeout flagged", got_to, 1);
        check(done_cyc - start_cyc >= POLL_LIMIT, "R7", "poll limit elapsed",
              done_cyc - start_cyc, POLL_LIMIT);
        check(bad_low == badlow0, "R4", "cs low gap", bad_low - badlow0, 0);
        stuck = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_write(6'h2B, 16'hA5C3);
        test_write(6'h00, 16'h0001);
        test_wral(16'h5A0F);
        test_timeout();
        test_write(6'h3F, 16'h8000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule